// File: doc/BRIEF.md
# Burst-Limited Shared-Bus Arbiter

This block decides which of four masters owns a shared 32-bit system bus: a processor core, a DMA engine, a slave port driven by an outside host, and an external bus master. Each master raises a request line and, while it owns the bus, pulses a per-beat valid for every 32-bit word it completes. The arbiter returns a registered one-hot grant. It counts the owner's completed beats and caps each tenure at a fixed number of words. When the cap is hit, ownership passes to a waiting master. If no other master is waiting, the owner gets a fresh tenure.

The DMA engine also presents the number of the channel it is about to serve. When a DMA grant serves a different channel than the previous DMA grant, the arbiter holds the bus dead for a fixed context-switch time. During that time beats are not counted.

Top module: `bus_tenure_arbiter`

## Requirements
- R1: The grant is registered and never has more than one bit set. A grant bit rises only at a clock edge where that master's request was high.
- R2: Synchronous active-high reset clears the grant, the beat count and the stall flag. If no request is high at an edge, the grant is zero after that edge.
- R3: `beat_cnt` goes up by one at each edge where the owner's `beat` bit is high and `stall` is low. `beat` bits of masters that do not own the bus have no effect.
- R4: At the edge that completes the BEAT_LIMIT-th beat (default 4), if any other master is requesting, the grant moves at that same edge to the next requester in round-robin order after the owner.
- R5: If no other master is requesting at that edge and the owner still requests, the owner keeps the grant and `beat_cnt` returns to 0.
- R6: An owner that drops its request loses the grant at the next edge. At that same edge the grant goes to the round-robin winner among the current requests, or to nobody.
- R7: Round-robin search starts at the index after the last owner and wraps. After reset the search starts at index 0. The indices are processor = 0, DMA = 1, host slave port = 2, external master = 3.
- R8: A DMA grant whose `dma_chan` differs from the channel of the previous DMA grant raises `stall` for 13 cycles, starting in the cycle after the grant edge. The first DMA grant after reset raises no stall, and neither does a grant for the same channel.
- R9: Beats are not counted while `stall` is high. `stall` drops at once when the DMA engine loses the grant.
- R10: `beat_cnt` reads 0 after every edge that makes a new grant, including a re-grant to the same master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | N_MASTERS | Request line per master |
| beat | input | N_MASTERS | Per-master valid for one completed 32-bit word |
| dma_chan | input | CH_W | Channel the DMA engine will serve when granted |
| gnt | output | N_MASTERS | Registered one-hot grant |
| stall | output | 1 | DMA context-switch dead time active |
| beat_cnt | output | CNT_W | Beats completed in the current tenure |

## Verification
The bench builds the block with its default values: four masters, a four-beat limit, a 13-cycle switch stall and a 3-bit channel number. With these values a forced handover is reached after four beats. The whole dead window, including the edge where the first beat after the stall is counted, fits in a few dozen cycles. Round-robin wrap from the top index back to the processor can be reached with only three active masters.

// File: rtl/bta_pkg.sv
package bta_pkg;
   typedef enum logic [1:0] {
      M_CORE     = 2'd0,
      M_DMA      = 2'd1,
      M_HOSTPORT = 2'd2,
      M_EXTMAST  = 2'd3
   } master_e;
endpackage

// File: rtl/bta_rr_pick.sv
module bta_rr_pick #(
   parameter int N_MASTERS = 4,
   parameter int IDX_W     = 2
) (
   input  logic [N_MASTERS-1:0] req,
   input  logic [IDX_W-1:0]     last,
   output logic [N_MASTERS-1:0] pick_oh,
   output logic [IDX_W-1:0]     pick_idx,
   output logic                 any
);
   always_comb begin
      pick_oh  = '0;
      pick_idx = last;
      any      = 1'b0;
      for (int k = 1; k <= N_MASTERS; k++) begin
         logic [IDX_W-1:0] cand;
         cand = IDX_W'((int'(last) + k) % N_MASTERS);
         if (!any && req[cand]) begin
            any           = 1'b1;
            pick_oh[cand] = 1'b1;
            pick_idx      = cand;
         end
      end
   end
endmodule

// File: rtl/bta_beat_counter.sv
module bta_beat_counter #(
   parameter int BEAT_LIMIT = 4,
   parameter int CNT_W      = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic             hit,
   output logic [CNT_W-1:0] cnt,
   output logic             at_limit
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(BEAT_LIMIT - 1);

   assign at_limit = hit && (cnt == LAST);

   always_ff @(posedge clk) begin
      if (rst)        cnt <= '0;
      else if (start) cnt <= '0;
      else if (hit)   cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/bta_switch_stall.sv
module bta_switch_stall #(
   parameter int CH_W      = 3,
   parameter int STALL_CYC = 13
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            dma_grant,
   input  logic            dma_lose,
   input  logic [CH_W-1:0] chan,
   output logic            stall
);
   generate
      if (STALL_CYC == 0) begin : g_nostall
         logic unused_in;
         assign unused_in = ^{clk, rst, dma_grant, dma_lose, chan};
         assign stall     = 1'b0;
      end else begin : g_stall
         localparam int SC_W = $clog2(STALL_CYC + 1);
         logic [SC_W-1:0] left;
         logic [CH_W-1:0] prev_chan;
         logic            seen;

         always_ff @(posedge clk) begin
            if (rst) begin
               left      <= '0;
               prev_chan <= '0;
               seen      <= 1'b0;
            end else if (dma_grant) begin
               seen      <= 1'b1;
               prev_chan <= chan;
               left      <= (seen && chan != prev_chan) ? SC_W'(STALL_CYC) : '0;
            end else if (dma_lose) begin
               left <= '0;
            end else if (left != '0) begin
               left <= left - 1'b1;
            end
         end
         assign stall = (left != '0);
      end
   endgenerate
endmodule

// File: rtl/bus_tenure_arbiter.sv
module bus_tenure_arbiter #(
   parameter int N_MASTERS  = 4,
   parameter int BEAT_LIMIT = 4,
   parameter int STALL_CYC  = 13,
   parameter int CH_W       = 3,
   parameter int DMA_IDX    = int'(bta_pkg::M_DMA),
   parameter int CNT_W      = (BEAT_LIMIT > 1) ? $clog2(BEAT_LIMIT) : 1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [N_MASTERS-1:0] req,
   input  logic [N_MASTERS-1:0] beat,
   input  logic [CH_W-1:0]      dma_chan,
   output logic [N_MASTERS-1:0] gnt,
   output logic                 stall,
   output logic [CNT_W-1:0]     beat_cnt
);
   localparam int IDX_W = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1;

   generate
      if (N_MASTERS < 2) begin : g_chk_n
         $error("bus_tenure_arbiter: N_MASTERS must be at least 2");
      end
      if (BEAT_LIMIT < 1) begin : g_chk_lim
         $error("bus_tenure_arbiter: BEAT_LIMIT must be at least 1");
      end
      if (DMA_IDX < 0 || DMA_IDX >= N_MASTERS) begin : g_chk_dma
         $error("bus_tenure_arbiter: DMA_IDX out of range");
      end
      if (CH_W < 1) begin : g_chk_ch
         $error("bus_tenure_arbiter: CH_W must be at least 1");
      end
   endgenerate

   logic [N_MASTERS-1:0] gnt_q;
   logic [IDX_W-1:0]     last_q;
   logic [N_MASTERS-1:0] pick_oh;
   logic [IDX_W-1:0]     pick_idx;
   logic                 pick_any;
   logic                 owner_req;
   logic                 beat_hit;
   logic                 at_limit;
   logic                 handover;
   logic                 stall_w;

   assign owner_req = |(gnt_q & req);
   assign beat_hit  = |(gnt_q & beat) && !stall_w;
   assign handover  = !owner_req || at_limit;

   bta_rr_pick #(.N_MASTERS(N_MASTERS), .IDX_W(IDX_W)) u_pick (
      .req      (req),
      .last     (last_q),
      .pick_oh  (pick_oh),
      .pick_idx (pick_idx),
      .any      (pick_any)
   );

   bta_beat_counter #(.BEAT_LIMIT(BEAT_LIMIT), .CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .start    (handover),
      .hit      (beat_hit),
      .cnt      (beat_cnt),
      .at_limit (at_limit)
   );

   bta_switch_stall #(.CH_W(CH_W), .STALL_CYC(STALL_CYC)) u_stall (
      .clk       (clk),
      .rst       (rst),
      .dma_grant (handover && pick_oh[DMA_IDX]),
      .dma_lose  (handover && !pick_oh[DMA_IDX]),
      .chan      (dma_chan),
      .stall     (stall_w)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         gnt_q  <= '0;
         last_q <= IDX_W'(N_MASTERS - 1);
      end else if (handover) begin
         gnt_q <= pick_oh;
         if (pick_any) last_q <= pick_idx;
      end
   end

   assign gnt   = gnt_q;
   assign stall = stall_w;
endmodule

// File: rtl/bta_checker.sv
module bta_checker #(
   parameter int N_MASTERS  = 4,
   parameter int BEAT_LIMIT = 4,
   parameter int CNT_W      = 2,
   parameter int DMA_IDX    = 1
) (
   input logic                 clk,
   input logic                 rst,
   input logic [N_MASTERS-1:0] req,
   input logic [N_MASTERS-1:0] beat,
   input logic [N_MASTERS-1:0] gnt,
   input logic                 stall,
   input logic [CNT_W-1:0]     beat_cnt
);
   AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $onehot0(gnt)); // R1

   AST_GNT_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
      ((gnt & ~$past(gnt)) != '0) |-> ((gnt & ~$past(req)) == '0)); // R1

   AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (rst)
      (req == '0) |=> (gnt == '0)); // R2

   AST_FORCED_MOVE: assert property (@(posedge clk) disable iff (rst)
      (beat_cnt == CNT_W'(BEAT_LIMIT - 1) && (gnt & beat) != '0 && !stall
       && (req & ~gnt) != '0) |=> (gnt != $past(gnt))); // R4

   AST_DROP_RELEASE: assert property (@(posedge clk) disable iff (rst)
      (gnt != '0 && (gnt & req) == '0) |=> ((gnt & $past(gnt)) == '0)); // R6

   AST_STALL_DMA_OWNS: assert property (@(posedge clk) disable iff (rst)
      stall |-> gnt[DMA_IDX]); // R8

   AST_STALL_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
      (stall && (gnt & req) != '0) |=> (beat_cnt == $past(beat_cnt))); // R9
endmodule

bind bus_tenure_arbiter bta_checker #(
   .N_MASTERS  (N_MASTERS),
   .BEAT_LIMIT (BEAT_LIMIT),
   .CNT_W      (CNT_W),
   .DMA_IDX    (DMA_IDX)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .req      (req),
   .beat     (beat),
   .gnt      (gnt),
   .stall    (stall),
   .beat_cnt (beat_cnt)
);

// File: tb/sim_bus_tenure_arbiter.sv
`timescale 1ns/1ps
module sim_bus_tenure_arbiter;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] req = '0;
   logic [3:0] beat = '0;
   logic [2:0] dma_chan = '0;
   logic [3:0] gnt;
   logic       stall;
   logic [1:0] beat_cnt;

   int total = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   bus_tenure_arbiter u0 (
      .clk      (clk),
      .rst      (rst),
      .req      (req),
      .beat     (beat),
      .dma_chan (dma_chan),
      .gnt      (gnt),
      .stall    (stall),
      .beat_cnt (beat_cnt)
   );

   task automatic tick;
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string rq, input int act, input int exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   task automatic do_reset;
      rst = 1'b1; req = '0; beat = '0; dma_chan = '0;
      tick; tick;
      rst = 1'b0;
   endtask

   task automatic t_reset;
      rst = 1'b1; req = 4'hF; beat = 4'hF;
      tick; tick;
      chk("R2 reset gnt", int'(gnt), 0);
      chk("R2 reset stall", int'(stall), 0);
      chk("R2 reset beat_cnt", int'(beat_cnt), 0);
      rst = 1'b0; beat = '0;
      tick;
      chk("R1 R7 first grant to index 0", int'(gnt), 1);
   endtask

   task automatic t_count;
      do_reset;
      req = 4'b0001; tick;
      chk("R1 single request granted", int'(gnt), 1);
      beat = 4'b1110; tick;
      chk("R3 non-owner beats ignored", int'(beat_cnt), 0);
      beat = 4'b0001; tick;
      chk("R3 count 1", int'(beat_cnt), 1);
      tick;
      chk("R3 count 2", int'(beat_cnt), 2);
      beat = '0; tick;
      chk("R3 holds without beat", int'(beat_cnt), 2);
      req = '0; tick;
      chk("R2 idle clears grant", int'(gnt), 0);
      req = 4'b0001; tick;
      chk("R10 new grant count zero", int'(beat_cnt), 0);
      req = '0; tick;
   endtask

   task automatic t_force;
      do_reset;
      req = 4'b0001; tick;
      req = 4'b1011; beat = 4'b0001;
      tick; tick; tick;
      chk("R3 count 3 before limit", int'(beat_cnt), 3);
      chk("R4 owner kept below limit", int'(gnt), 1);
      tick;
      chk("R4 forced handover to next", int'(gnt), 2);
      chk("R10 count zero after handover", int'(beat_cnt), 0);
      beat = '0; req = '0; tick;
   endtask

   task automatic t_keep;
      do_reset;
      req = 4'b0001; tick;
      beat = 4'b0001;
      tick; tick; tick; tick;
      chk("R5 alone keeps bus", int'(gnt), 1);
      chk("R5 R10 count restarts", int'(beat_cnt), 0);
      tick;
      chk("R5 new tenure counts", int'(beat_cnt), 1);
      beat = '0; req = '0; tick;
   endtask

   task automatic t_drop;
      do_reset;
      req = 4'b0101; tick;
      chk("R7 lowest index after reset", int'(gnt), 1);
      req = 4'b0100; tick;
      chk("R6 drop hands to waiter", int'(gnt), 4);
      req = 4'b0000; tick;
      chk("R6 drop with no waiter", int'(gnt), 0);
   endtask

   task automatic t_wrap;
      do_reset;
      req = 4'b1000; tick;
      chk("R1 top index granted", int'(gnt), 8);
      req = 4'b1101; beat = 4'b1000;
      tick; tick; tick; tick;
      chk("R7 wrap to index 0", int'(gnt), 1);
      beat = 4'b0001;
      tick; tick; tick; tick;
      chk("R7 skip idle index 1", int'(gnt), 4);
      beat = '0; req = '0; tick;
   endtask

   task automatic t_stall;
      do_reset;
      dma_chan = 3'd1; req = 4'b0010; tick;
      chk("R8 first DMA grant", int'(gnt), 2);
      chk("R8 first DMA grant no stall", int'(stall), 0);
      req = '0; tick;
      dma_chan = 3'd2; req = 4'b0010; tick;
      chk("R8 switch raises stall", int'(stall), 1);
      beat = 4'b0010;
      for (int k = 1; k <= 14; k++) begin
         tick;
         if (k == 12) begin
            chk("R8 stall still high", int'(stall), 1);
            chk("R9 no count in stall", int'(beat_cnt), 0);
         end
         if (k == 13) begin
            chk("R8 stall ends after 13", int'(stall), 0);
            chk("R9 last stall beat dropped", int'(beat_cnt), 0);
         end
         if (k == 14) chk("R9 counts after stall", int'(beat_cnt), 1);
      end
      beat = '0; req = '0; tick;
      req = 4'b0010; tick;
      chk("R8 same channel no stall", int'(stall), 0);
      req = '0; tick;
      dma_chan = 3'd5; req = 4'b0010; tick;
      chk("R8 second switch stalls", int'(stall), 1);
      req = '0; tick;
      chk("R9 stall drops on release", int'(stall), 0);
      chk("R6 DMA released", int'(gnt), 0);
   endtask

   initial begin
      t_reset;
      t_count;
      t_force;
      t_keep;
      t_drop;
      t_wrap;
      t_stall;
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         total++;
         fails++;
         $display("FAIL watchdog all requirements actual=timeout expected=completion");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end
endmodule